// File: doc/BRIEF.md
# Sampled-Control Storage Element Emulator

This block stands in for a single storage element (edge-triggered flop, transparent latch, or a bare set/clear cell) in a design that runs from one fast global clock. The emulated clock, the enable, and every reset or set/clear control come in as ordinary data inputs. The block samples them on each global clock edge and rebuilds the chosen storage behaviour from three internal registers: the previous emulated-clock level, the previous next-state value, and the previous output.

Parameters pick the mode, the width, the polarity of every control, the sync and async reset values, the initial value, and whether the enable outranks the sync reset. Asynchronous controls act combinationally on the output within the global cycle in which they are asserted. Their effect persists afterwards because the previous-output register captures the forced value. The global reset `rst` is synchronous. It loads the initial value into both value registers and loads the active clock level into the clock-history register.

All ports are plain signals. None carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ffemu_cell`

## Requirements
- R1: While `rst` is high at a global clock edge, the previous-output and previous-next-state registers load `INIT_VAL`. With no asynchronous control active, `q` equals `INIT_VAL` in the first global cycle after reset.
- R2: In edge mode, `q` takes the next-state value registered on the previous global edge only in a global cycle where `emu_clk` is at level `CLK_POL` and its registered previous level is not. In every other cycle with no asynchronous control active, `q` keeps its previous global-cycle value. `CLK_POL`=1 selects rising edges and `CLK_POL`=0 selects falling edges.
- R3: When `HAS_EN` is set and `en` differs from `EN_POL`, the next-state value is the current `q`, so an active edge leaves the stored value unchanged.
- R4: When `HAS_SRST` is set and `srst` equals `SRST_POL`, the next-state value becomes `SRST_VAL`, subject to R5.
- R5: With `EN_OVER_SRST`=1, the sync reset only applies while the enable is active, and an inactive enable holds the value. With `EN_OVER_SRST`=0, the sync reset applies whatever the enable is.
- R6: In latch mode, `q` equals `d` in the same global cycle while `en` equals `EN_POL`. Otherwise `q` holds the previous-output register.
- R7: With `HAS_SR` set, each bit of `q` is forced to 1 where its `set` bit equals `SET_POL` and to 0 where its `clr` bit equals `CLR_POL`. Clear wins when both are active. Set and clear override the async reset.
- R8: With `HAS_ARST` set, `q` equals `ARST_VAL` in any global cycle where `arst` equals `ARST_POL`, apart from bits that R7 forces. After release, the forced value persists until the storage function next updates.
- R9: In set/clear-only mode, with no set or clear active, `q` holds its previous global-cycle value.
- R10: Holding `emu_clk` at the active level through reset and afterwards produces no edge, and the stored value stays `INIT_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global sampling clock |
| rst | input | 1 | Synchronous global reset, active high |
| emu_clk | input | 1 | Emulated clock, sampled as data |
| d | input | WIDTH | Data input |
| en | input | 1 | Clock enable (edge mode) or gate (latch mode) |
| srst | input | 1 | Synchronous reset control |
| arst | input | 1 | Asynchronous reset control |
| set | input | WIDTH | Per-bit asynchronous set |
| clr | input | WIDTH | Per-bit asynchronous clear |
| q | output | WIDTH | Emulated storage output |

## Verification
Four configurations run side by side on shared stimulus, and each is compared every global cycle against a behavioural reference:

- a rising-edge flop with sync reset over enable and an active-low async reset;
- a falling-edge flop with active-low enable ranking above its sync reset, plus set/clear;
- a latch with async reset;
- a set/clear-only cell with active-low controls.

Toggling the emulated clock while data changes shows which edge direction each flop takes. Disabled-enable phases separate hold from load. Enable off with sync reset on is the one pattern that tells the two priority orders apart, because one flop must reset while the other must hold. Overlapping set and clear vectors expose clear dominance. A one-cycle async reset followed by quiet cycles shows that the forced value persists through the output register.

// File: rtl/ffemu_pkg.sv
package ffemu_pkg;
  typedef enum logic [1:0] {
    FFE_EDGE   = 2'd0,
    FFE_LATCH  = 2'd1,
    FFE_SRONLY = 2'd2
  } ffe_mode_e;
endpackage

// File: rtl/ffemu_edge_det.sv
// Keeps the emulated clock level seen on the previous global edge and flags
// an active transition. Reset primes history to the active level (no false edge).
module ffemu_edge_det #(
  parameter bit CLK_POL = 1'b1
) (
  input  logic gclk,
  input  logic rst,
  input  logic emu_clk,
  output logic edge_hit
);
  logic prev_lvl;

  always_ff @(posedge gclk) begin
    if (rst) prev_lvl <= CLK_POL;
    else     prev_lvl <= emu_clk;
  end

  assign edge_hit = (emu_clk == CLK_POL) && (prev_lvl != CLK_POL);
endmodule

// File: rtl/ffemu_next_state.sv
// Builds the value an active edge would load, with the enable/sync-reset order
// picked by EN_OVER_SRST.
module ffemu_next_state #(
  parameter int                WIDTH        = 8,
  parameter bit                HAS_EN       = 1'b1,
  parameter bit                EN_POL       = 1'b1,
  parameter bit                HAS_SRST     = 1'b1,
  parameter bit                SRST_POL     = 1'b1,
  parameter logic [WIDTH-1:0]  SRST_VAL     = '0,
  parameter bit                EN_OVER_SRST = 1'b0
) (
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] q_now,
  input  logic             en,
  input  logic             srst,
  output logic [WIDTH-1:0] nxt
);
  logic en_on;
  logic srst_on;

  assign en_on   = HAS_EN   ? (en == EN_POL)     : 1'b1;
  assign srst_on = HAS_SRST ? (srst == SRST_POL) : 1'b0;

  generate
    if (EN_OVER_SRST) begin : g_rst_inside
      logic [WIDTH-1:0] rst_sel;
      assign rst_sel = srst_on ? SRST_VAL : d;
      assign nxt     = en_on ? rst_sel : q_now;
    end else begin : g_rst_outside
      logic [WIDTH-1:0] hold_sel;
      assign hold_sel = en_on ? d : q_now;
      assign nxt      = srst_on ? SRST_VAL : hold_sel;
    end
  endgenerate
endmodule

// File: rtl/ffemu_async_ovr.sv
// Applies async reset, then per-bit set and clear (clear strongest), on top of
// the sampled value within the same global cycle.
module ffemu_async_ovr #(
  parameter int               WIDTH    = 8,
  parameter bit               HAS_ARST = 1'b1,
  parameter bit               ARST_POL = 1'b1,
  parameter logic [WIDTH-1:0] ARST_VAL = '0,
  parameter bit               HAS_SR   = 1'b1,
  parameter bit               SET_POL  = 1'b1,
  parameter bit               CLR_POL  = 1'b1
) (
  input  logic [WIDTH-1:0] base,
  input  logic             arst,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] after_arst;

  generate
    if (HAS_ARST) begin : g_arst
      assign after_arst = (arst == ARST_POL) ? ARST_VAL : base;
    end else begin : g_no_arst
      assign after_arst = base;
    end

    if (HAS_SR) begin : g_sr
      logic [WIDTH-1:0] set_on;
      logic [WIDTH-1:0] clr_on;
      assign set_on = SET_POL ? set : ~set;
      assign clr_on = CLR_POL ? clr : ~clr;
      assign q      = (after_arst | set_on) & ~clr_on;
    end else begin : g_no_sr
      assign q = after_arst;
    end
  endgenerate
endmodule

// File: rtl/ffemu_cell.sv
module ffemu_cell
  import ffemu_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter ffe_mode_e        MODE         = FFE_EDGE,
  parameter bit               CLK_POL      = 1'b1,
  parameter bit               HAS_EN       = 1'b1,
  parameter bit               EN_POL       = 1'b1,
  parameter bit               HAS_SRST     = 1'b1,
  parameter bit               SRST_POL     = 1'b1,
  parameter logic [WIDTH-1:0] SRST_VAL     = '0,
  parameter bit               EN_OVER_SRST = 1'b0,
  parameter bit               HAS_ARST     = 1'b1,
  parameter bit               ARST_POL     = 1'b1,
  parameter logic [WIDTH-1:0] ARST_VAL     = '0,
  parameter bit               HAS_SR       = 1'b1,
  parameter bit               SET_POL      = 1'b1,
  parameter bit               CLR_POL      = 1'b1,
  parameter logic [WIDTH-1:0] INIT_VAL     = '0
) (
  input  logic             gclk,
  input  logic             rst,
  input  logic             emu_clk,
  input  logic [WIDTH-1:0] d,
  input  logic             en,
  input  logic             srst,
  input  logic             arst,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] base;

  // previous output: captures forced async values so they persist
  always_ff @(posedge gclk) begin
    if (rst) prev_q <= INIT_VAL;
    else     prev_q <= q;
  end

  generate
    if (MODE == FFE_EDGE) begin : g_edge
      logic             edge_hit;
      logic [WIDTH-1:0] nxt;
      logic [WIDTH-1:0] prev_nxt;

      ffemu_edge_det #(.CLK_POL(CLK_POL)) u_edge (
        .gclk     (gclk),
        .rst      (rst),
        .emu_clk  (emu_clk),
        .edge_hit (edge_hit)
      );

      ffemu_next_state #(
        .WIDTH(WIDTH), .HAS_EN(HAS_EN), .EN_POL(EN_POL),
        .HAS_SRST(HAS_SRST), .SRST_POL(SRST_POL), .SRST_VAL(SRST_VAL),
        .EN_OVER_SRST(EN_OVER_SRST)
      ) u_next (
        .d     (d),
        .q_now (q),
        .en    (en),
        .srst  (srst),
        .nxt   (nxt)
      );

      always_ff @(posedge gclk) begin
        if (rst) prev_nxt <= INIT_VAL;
        else     prev_nxt <= nxt;
      end

      assign base = edge_hit ? prev_nxt : prev_q;
    end else if (MODE == FFE_LATCH) begin : g_latch
      assign base = (en == EN_POL) ? d : prev_q;
    end else begin : g_sronly
      assign base = prev_q;
    end
  endgenerate

  ffemu_async_ovr #(
    .WIDTH(WIDTH), .HAS_ARST(HAS_ARST), .ARST_POL(ARST_POL), .ARST_VAL(ARST_VAL),
    .HAS_SR(HAS_SR), .SET_POL(SET_POL), .CLR_POL(CLR_POL)
  ) u_ovr (
    .base (base),
    .arst (arst),
    .set  (set),
    .clr  (clr),
    .q    (q)
  );
endmodule

// File: rtl/ffemu_cell_chk.sv
module ffemu_cell_chk
  import ffemu_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter ffe_mode_e        MODE         = FFE_EDGE,
  parameter bit               CLK_POL      = 1'b1,
  parameter bit               EN_POL       = 1'b1,
  parameter bit               HAS_ARST     = 1'b1,
  parameter bit               ARST_POL     = 1'b1,
  parameter logic [WIDTH-1:0] ARST_VAL     = '0,
  parameter bit               HAS_SR       = 1'b1,
  parameter bit               SET_POL      = 1'b1,
  parameter bit               CLR_POL      = 1'b1
) (
  input logic             gclk,
  input logic             rst,
  input logic             emu_clk,
  input logic [WIDTH-1:0] d,
  input logic             en,
  input logic             arst,
  input logic [WIDTH-1:0] set,
  input logic [WIDTH-1:0] clr,
  input logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] set_on;
  logic [WIDTH-1:0] clr_on;
  logic             arst_on;
  logic             async_any;
  logic             post_rst;

  assign set_on    = HAS_SR ? (SET_POL ? set : ~set) : '0;
  assign clr_on    = HAS_SR ? (CLR_POL ? clr : ~clr) : '0;
  assign arst_on   = HAS_ARST && (arst == ARST_POL);
  assign async_any = arst_on || (|set_on) || (|clr_on);

  // set once a full non-reset cycle has passed, so $past never reaches reset
  always_ff @(posedge gclk) begin
    if (rst) post_rst <= 1'b0;
    else     post_rst <= 1'b1;
  end

  assert_hold_no_edge_R2: assert property (@(posedge gclk) disable iff (rst)
    (post_rst && MODE == FFE_EDGE && !async_any &&
     !(emu_clk == CLK_POL && $past(emu_clk) != CLK_POL)) |-> (q == $past(q)));

  assert_latch_open_R6: assert property (@(posedge gclk) disable iff (rst)
    (MODE == FFE_LATCH && en == EN_POL && !async_any) |-> (q == d));

  assert_latch_closed_R6: assert property (@(posedge gclk) disable iff (rst)
    (post_rst && MODE == FFE_LATCH && en != EN_POL && !async_any) |-> (q == $past(q)));

  assert_clear_wins_R7: assert property (@(posedge gclk) disable iff (rst)
    (|clr_on) |-> ((q & clr_on) == '0));

  assert_set_forces_R7: assert property (@(posedge gclk) disable iff (rst)
    (|(set_on & ~clr_on)) |-> ((q & set_on & ~clr_on) == (set_on & ~clr_on)));

  assert_arst_value_R8: assert property (@(posedge gclk) disable iff (rst)
    (arst_on && !(|set_on) && !(|clr_on)) |-> (q == ARST_VAL));

  assert_sronly_hold_R9: assert property (@(posedge gclk) disable iff (rst)
    (post_rst && MODE == FFE_SRONLY && !async_any) |-> (q == $past(q)));
endmodule

bind ffemu_cell ffemu_cell_chk #(
  .WIDTH(WIDTH), .MODE(MODE), .CLK_POL(CLK_POL), .EN_POL(EN_POL),
  .HAS_ARST(HAS_ARST), .ARST_POL(ARST_POL), .ARST_VAL(ARST_VAL),
  .HAS_SR(HAS_SR), .SET_POL(SET_POL), .CLR_POL(CLR_POL)
) u_chk (
  .gclk(gclk), .rst(rst), .emu_clk(emu_clk), .d(d), .en(en),
  .arst(arst), .set(set), .clr(clr), .q(q)
);

// File: tb/ffemu_cell_bench.sv
// Behavioural model of one emulated storage element, advanced once per global cycle.
module ffemu_ref
  import ffemu_pkg::*;
#(
  parameter int               WIDTH        = 8,
  parameter ffe_mode_e        MODE         = FFE_EDGE,
  parameter bit               CLK_POL      = 1'b1,
  parameter bit               HAS_EN       = 1'b1,
  parameter bit               EN_POL       = 1'b1,
  parameter bit               HAS_SRST     = 1'b1,
  parameter bit               SRST_POL     = 1'b1,
  parameter logic [WIDTH-1:0] SRST_VAL     = '0,
  parameter bit               EN_OVER_SRST = 1'b0,
  parameter bit               HAS_ARST     = 1'b1,
  parameter bit               ARST_POL     = 1'b1,
  parameter logic [WIDTH-1:0] ARST_VAL     = '0,
  parameter bit               HAS_SR       = 1'b1,
  parameter bit               SET_POL      = 1'b1,
  parameter bit               CLR_POL      = 1'b1,
  parameter logic [WIDTH-1:0] INIT_VAL     = '0
) (
  input  logic             gclk,
  input  logic             rst,
  input  logic             emu_clk,
  input  logic [WIDTH-1:0] d,
  input  logic             en,
  input  logic             srst,
  input  logic             arst,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] q_exp
);
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] pending;
  logic             last_lvl;

  always_comb begin
    q_exp = stored;
    case (MODE)
      FFE_EDGE:  if (emu_clk == CLK_POL && last_lvl != CLK_POL) q_exp = pending;
      FFE_LATCH: if (en == EN_POL) q_exp = d;
      default:   ;
    endcase
    if (HAS_ARST && arst == ARST_POL) q_exp = ARST_VAL;
    if (HAS_SR) begin
      for (int b = 0; b < WIDTH; b++) begin
        if (clr[b] == CLR_POL)      q_exp[b] = 1'b0;
        else if (set[b] == SET_POL) q_exp[b] = 1'b1;
      end
    end
  end

  always @(posedge gclk) begin
    if (rst) begin
      stored   <= INIT_VAL;
      pending  <= INIT_VAL;
      last_lvl <= CLK_POL;
    end else begin
      stored   <= q_exp;
      last_lvl <= emu_clk;
      if (HAS_SRST && srst == SRST_POL && !(EN_OVER_SRST && HAS_EN && en != EN_POL))
        pending <= SRST_VAL;
      else if (HAS_EN && en != EN_POL)
        pending <= q_exp;
      else
        pending <= d;
    end
  end
endmodule

module ffemu_cell_bench;
  import ffemu_pkg::*;

  localparam int CLK_P = 10;

  logic       gclk = 1'b0;
  logic       rst;
  logic       eclk;
  logic [7:0] dv;
  logic       en_l, srst_l, arst_l;
  logic [7:0] set_v, clr_v;
  logic       run_cmp = 1'b0;
  logic       done = 1'b0;
  string      tag = "R1";
  int         checks = 0;
  int         errors = 0;

  logic [7:0] q_a, q_b, q_c, q_d;
  logic [7:0] e_a, e_b, e_c, e_d;

  always #(CLK_P/2) gclk = ~gclk;

  // A: rising edge, sync reset outranks enable, active-low async reset
  ffemu_cell #(.WIDTH(8), .MODE(FFE_EDGE), .CLK_POL(1'b1), .HAS_EN(1'b1), .EN_POL(1'b1),
    .HAS_SRST(1'b1), .SRST_POL(1'b1), .SRST_VAL(8'h5A), .EN_OVER_SRST(1'b0),
    .HAS_ARST(1'b1), .ARST_POL(1'b0), .ARST_VAL(8'hC3), .HAS_SR(1'b0),
    .SET_POL(1'b1), .CLR_POL(1'b1), .INIT_VAL(8'h11)) u_ffemu_cell (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(en_l), .srst(srst_l),
    .arst(~arst_l), .set(set_v), .clr(clr_v), .q(q_a));
  ffemu_ref #(.WIDTH(8), .MODE(FFE_EDGE), .CLK_POL(1'b1), .HAS_EN(1'b1), .EN_POL(1'b1),
    .HAS_SRST(1'b1), .SRST_POL(1'b1), .SRST_VAL(8'h5A), .EN_OVER_SRST(1'b0),
    .HAS_ARST(1'b1), .ARST_POL(1'b0), .ARST_VAL(8'hC3), .HAS_SR(1'b0),
    .SET_POL(1'b1), .CLR_POL(1'b1), .INIT_VAL(8'h11)) u_ref_a (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(en_l), .srst(srst_l),
    .arst(~arst_l), .set(set_v), .clr(clr_v), .q_exp(e_a));

  // B: falling edge, active-low enable outranks active-low sync reset, set/clear
  ffemu_cell #(.WIDTH(8), .MODE(FFE_EDGE), .CLK_POL(1'b0), .HAS_EN(1'b1), .EN_POL(1'b0),
    .HAS_SRST(1'b1), .SRST_POL(1'b0), .SRST_VAL(8'hA5), .EN_OVER_SRST(1'b1),
    .HAS_ARST(1'b0), .ARST_POL(1'b1), .ARST_VAL(8'h00), .HAS_SR(1'b1),
    .SET_POL(1'b1), .CLR_POL(1'b1), .INIT_VAL(8'h22)) u_ffemu_cell_b (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(~en_l), .srst(~srst_l),
    .arst(arst_l), .set(set_v), .clr(clr_v), .q(q_b));
  ffemu_ref #(.WIDTH(8), .MODE(FFE_EDGE), .CLK_POL(1'b0), .HAS_EN(1'b1), .EN_POL(1'b0),
    .HAS_SRST(1'b1), .SRST_POL(1'b0), .SRST_VAL(8'hA5), .EN_OVER_SRST(1'b1),
    .HAS_ARST(1'b0), .ARST_POL(1'b1), .ARST_VAL(8'h00), .HAS_SR(1'b1),
    .SET_POL(1'b1), .CLR_POL(1'b1), .INIT_VAL(8'h22)) u_ref_b (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(~en_l), .srst(~srst_l),
    .arst(arst_l), .set(set_v), .clr(clr_v), .q_exp(e_b));

  // C: latch with active-high async reset
  ffemu_cell #(.WIDTH(8), .MODE(FFE_LATCH), .CLK_POL(1'b1), .HAS_EN(1'b1), .EN_POL(1'b1),
    .HAS_SRST(1'b0), .SRST_POL(1'b1), .SRST_VAL(8'h00), .EN_OVER_SRST(1'b0),
    .HAS_ARST(1'b1), .ARST_POL(1'b1), .ARST_VAL(8'h0F), .HAS_SR(1'b0),
    .SET_POL(1'b1), .CLR_POL(1'b1), .INIT_VAL(8'h33)) u_ffemu_cell_c (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(en_l), .srst(srst_l),
    .arst(arst_l), .set(set_v), .clr(clr_v), .q(q_c));
  ffemu_ref #(.WIDTH(8), .MODE(FFE_LATCH), .CLK_POL(1'b1), .HAS_EN(1'b1), .EN_POL(1'b1),
    .HAS_SRST(1'b0), .SRST_POL(1'b1), .SRST_VAL(8'h00), .EN_OVER_SRST(1'b0),
    .HAS_ARST(1'b1), .ARST_POL(1'b1), .ARST_VAL(8'h0F), .HAS_SR(1'b0),
    .SET_POL(1'b1), .CLR_POL(1'b1), .INIT_VAL(8'h33)) u_ref_c (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(en_l), .srst(srst_l),
    .arst(arst_l), .set(set_v), .clr(clr_v), .q_exp(e_c));

  // D: set/clear only, active-low set and clear
  ffemu_cell #(.WIDTH(8), .MODE(FFE_SRONLY), .CLK_POL(1'b1), .HAS_EN(1'b0), .EN_POL(1'b1),
    .HAS_SRST(1'b0), .SRST_POL(1'b1), .SRST_VAL(8'h00), .EN_OVER_SRST(1'b0),
    .HAS_ARST(1'b0), .ARST_POL(1'b1), .ARST_VAL(8'h00), .HAS_SR(1'b1),
    .SET_POL(1'b0), .CLR_POL(1'b0), .INIT_VAL(8'h44)) u_ffemu_cell_d (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(en_l), .srst(srst_l),
    .arst(arst_l), .set(~set_v), .clr(~clr_v), .q(q_d));
  ffemu_ref #(.WIDTH(8), .MODE(FFE_SRONLY), .CLK_POL(1'b1), .HAS_EN(1'b0), .EN_POL(1'b1),
    .HAS_SRST(1'b0), .SRST_POL(1'b1), .SRST_VAL(8'h00), .EN_OVER_SRST(1'b0),
    .HAS_ARST(1'b0), .ARST_POL(1'b1), .ARST_VAL(8'h00), .HAS_SR(1'b1),
    .SET_POL(1'b0), .CLR_POL(1'b0), .INIT_VAL(8'h44)) u_ref_d (
    .gclk(gclk), .rst(rst), .emu_clk(eclk), .d(dv), .en(en_l), .srst(srst_l),
    .arst(arst_l), .set(~set_v), .clr(~clr_v), .q_exp(e_d));

  task automatic check(input string req, input string who, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cell %s: actual %h expected %h at %0t", req, who, act, exp, $time);
    end
  endtask

  // drive at posedge + 1
  task automatic hold(input int n);
    repeat (n) begin
      @(posedge gclk);
      #1;
    end
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      eclk = ~eclk;
      hold(2);
    end
  endtask

  // every-cycle comparison against the reference, mid-cycle
  always @(negedge gclk) begin
    if (run_cmp && !rst) begin
      check(tag, "A", q_a, e_a);
      check(tag, "B", q_b, e_b);
      check(tag, "C", q_c, e_c);
      check(tag, "D", q_d, e_d);
    end
  end

  initial begin
    rst = 1'b1; eclk = 1'b1; dv = 8'h00; en_l = 1'b0; srst_l = 1'b0;
    arst_l = 1'b0; set_v = 8'h00; clr_v = 8'h00;
    hold(3);
    rst = 1'b0;
    @(negedge gclk);
    check("R1", "A", q_a, 8'h11);
    check("R1", "B", q_b, 8'h22);
    check("R1", "C", q_c, 8'h33);
    check("R1", "D", q_d, 8'h44);
    run_cmp = 1'b1;

    // R10: emulated clock stays at A's active level across reset
    tag = "R10";
    hold(1);
    en_l = 1'b1; dv = 8'h99;
    hold(3);
    @(negedge gclk);
    check("R10", "A", q_a, 8'h11);
    hold(1);

    tag = "R2";
    for (int i = 0; i < 6; i++) begin
      dv = 8'h13 + 8'(i * 8'h21);
      toggle(1);
    end

    tag = "R3";
    en_l = 1'b0;
    for (int i = 0; i < 4; i++) begin
      dv = 8'hE0 + 8'(i);
      toggle(1);
    end

    tag = "R4";
    en_l = 1'b1; srst_l = 1'b1; dv = 8'h66;
    toggle(4);

    tag = "R5";
    srst_l = 1'b0; dv = 8'h3C;
    toggle(4);
    en_l = 1'b0; srst_l = 1'b1; dv = 8'h81;
    toggle(4);
    @(negedge gclk);
    check("R5", "A", q_a, 8'h5A);
    check("R5", "B", q_b, 8'h3C);
    hold(1);
    srst_l = 1'b0;

    tag = "R6";
    en_l = 1'b1;
    for (int i = 0; i < 4; i++) begin
      dv = 8'h50 + 8'(i);
      hold(1);
    end
    en_l = 1'b0;
    for (int i = 0; i < 4; i++) begin
      dv = 8'h70 + 8'(i);
      hold(1);
    end
    @(negedge gclk);
    check("R6", "C", q_c, 8'h53);
    hold(1);

    tag = "R7";
    set_v = 8'h0F; clr_v = 8'h00;
    hold(2);
    set_v = 8'hF0; clr_v = 8'h3C;
    hold(2);
    @(negedge gclk);
    check("R7", "D", q_d, 8'hC3);
    hold(1);
    tag = "R9";
    set_v = 8'h00; clr_v = 8'h00;
    hold(3);
    @(negedge gclk);
    check("R9", "D", q_d, 8'hC3);
    hold(1);

    tag = "R8";
    arst_l = 1'b1;
    hold(1);
    arst_l = 1'b0;
    hold(3);
    @(negedge gclk);
    check("R8", "A", q_a, 8'hC3);
    check("R8", "C", q_c, 8'h0F);
    hold(1);
    en_l = 1'b1; dv = 8'h77;
    toggle(4);

    run_cmp = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule